// File: doc/BRIEF.md
# Serial-Loaded Latched Switch Controller

This block is the digital control for an array of independent on/off switches. A control word is loaded one bit at a time into a shift register. The register feeds a latch bank, and the latch bank drives one enable line per switch. A logic 1 in a channel's position turns that switch on and a 0 turns it off. The last shift stage also drives a serial output, so several controllers can be chained into one long serial path.

The latch bank has three modes. While the active-low latch enable is low, the bank is transparent and the switch enables follow the shift register. When the enable returns high, the bank freezes, and shifting has no further effect on the switches. An active-high clear turns every switch off at once. It takes effect without waiting for a clock edge and overrides every other input. Clear leaves the shift register untouched, so a later latch-enable pulse brings the stored word back.

The shift register moves on a rising clock edge only when the shift qualifier is high. A board-level shift clock is modelled as the system clock together with that qualifier. The serial input must meet a 15 ns setup window before each qualified edge and a 35 ns hold window after it.

Top module: `swctl_serial_latch`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears the shift register and the latch bank. After reset every switch enable is 0 and the serial output is 0.
- R2: On a rising clock edge with shift_en high, bit 0 of the shift register takes ser_in and every stage k moves to stage k+1. With shift_en low the register keeps its contents.
- R3: While le_n is low and clr is low, sw_en equals the shift register contents. It updates in the same cycle as a shift.
- R4: While le_n is high and clr is low, sw_en does not change, whatever shifting takes place.
- R5: When le_n rises, sw_en keeps the shift register value present at that moment.
- R6: While clr is high, every bit of sw_en is 0 at once, without waiting for a clock edge, whatever the values of le_n and shift_en.
- R7: Clear does not alter the shift register. After clr falls with le_n high, sw_en stays 0 until a low pulse on le_n, which restores the stored word.
- R8: ser_out always equals the last shift stage (switch index N_CH-1). With le_n low and clr low it matches sw_en[N_CH-1].
- R9: After N_CH qualified shifts, the bit shifted in first drives switch N_CH-1 and the bit shifted in last drives switch 0. Bit i of sw_en controls switch i.
- R10: ser_in must stay stable from 15 ns before to 35 ns after every qualified rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; shifting and latch updates happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data input, entering stage 0 |
| shift_en | input | 1 | Qualifies a rising edge as a shift edge |
| le_n | input | 1 | Active-low latch enable: low is transparent, high holds |
| clr | input | 1 | Active-high clear of all switch enables, overriding all inputs |
| sw_en | output | N_CH | Switch enables, bit i for switch i, 1 = on |
| ser_out | output | 1 | Serial output, copy of the last shift stage |

## Verification
The bench uses the default width of eight channels. At this width every possible control word can be loaded serially and then latched: all 256 words, each checked after a latch pulse. Every load also checks that the outputs held the previous word while the new one was shifting in, and that the bit order matches the switch numbering. Directed sequences cover the remaining modes: transparent shifting, idle edges with the qualifier low, clear in both latch modes (including the immediate response between clock edges), and the restore after clear. A timing monitor measures the setup and hold margins of the serial input around each qualified edge.

// File: rtl/swctl_pkg.sv
package swctl_pkg;

    localparam int SW_COUNT = 8;

    typedef enum logic [1:0] {
        LAT_CLEAR  = 2'd0,
        LAT_FOLLOW = 2'd1,
        LAT_HOLD   = 2'd2
    } lat_mode_e;

    typedef struct packed {
        logic clr;
        logic le_n;
    } lat_ctl_t;

    // Clear has priority, then the active-low enable selects follow or hold.
    function automatic lat_mode_e lat_mode(input lat_ctl_t ctl);
        if (ctl.clr)
            return LAT_CLEAR;
        else if (!ctl.le_n)
            return LAT_FOLLOW;
        else
            return LAT_HOLD;
    endfunction

endpackage

// File: rtl/swctl_shift_reg.sv
module swctl_shift_reg #(
    parameter int N_CH = swctl_pkg::SW_COUNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic            ser_in,
    output logic [N_CH-1:0] shift_q,
    output logic [N_CH-1:0] shift_nx
);

    always_comb begin
        if (shift_en)
            shift_nx = {shift_q[N_CH-2:0], ser_in};
        else
            shift_nx = shift_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            shift_q <= '0;
        else
            shift_q <= shift_nx;
    end

endmodule

// File: rtl/swctl_latch_bank.sv
module swctl_latch_bank #(
    parameter int N_CH = swctl_pkg::SW_COUNT
) (
    input  logic                clk,
    input  logic                rst,
    input  swctl_pkg::lat_ctl_t ctl,
    input  logic [N_CH-1:0]     load_d,
    input  logic [N_CH-1:0]     pass_d,
    output logic [N_CH-1:0]     sw_en
);
    import swctl_pkg::*;

    lat_mode_e mode;
    assign mode = lat_mode(ctl);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic held_q;
        logic out_b;

        always_ff @(posedge clk) begin
            if (rst)
                held_q <= 1'b0;
            else begin
                case (mode)
                    LAT_CLEAR:  held_q <= 1'b0;
                    LAT_FOLLOW: held_q <= load_d[i];
                    default:    held_q <= held_q;
                endcase
            end
        end

        always_comb begin
            case (mode)
                LAT_CLEAR:  out_b = 1'b0;
                LAT_FOLLOW: out_b = pass_d[i];
                default:    out_b = held_q;
            endcase
        end

        assign sw_en[i] = out_b;
    end

endmodule

// File: rtl/swctl_serial_latch.sv
module swctl_serial_latch #(
    parameter int N_CH = swctl_pkg::SW_COUNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ser_in,
    input  logic            shift_en,
    input  logic            le_n,
    input  logic            clr,
    output logic [N_CH-1:0] sw_en,
    output logic            ser_out
);
    import swctl_pkg::*;

    logic [N_CH-1:0] shift_q;
    logic [N_CH-1:0] shift_nx;
    lat_ctl_t        ctl;

    assign ctl.clr  = clr;
    assign ctl.le_n = le_n;

    swctl_shift_reg #(.N_CH(N_CH)) u_sr (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .ser_in   (ser_in),
        .shift_q  (shift_q),
        .shift_nx (shift_nx)
    );

    // Load with the next register value so the held word matches the
    // transparent view at the moment the enable rises.
    swctl_latch_bank #(.N_CH(N_CH)) u_lat (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .load_d (shift_nx),
        .pass_d (shift_q),
        .sw_en  (sw_en)
    );

    assign ser_out = shift_q[N_CH-1];

endmodule

// File: rtl/swctl_chk.sv
module swctl_chk #(
    parameter int N_CH = swctl_pkg::SW_COUNT
) (
    input logic            clk,
    input logic            rst,
    input logic            ser_in,
    input logic            shift_en,
    input logic            le_n,
    input logic            clr,
    input logic [N_CH-1:0] sw_en,
    input logic            ser_out,
    input logic [N_CH-1:0] shift_q
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (sw_en == '0 && ser_out == 1'b0));

    // R2
    shift_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !$past(rst)) |=> shift_q == {$past(shift_q[N_CH-2:0]), $past(ser_in)});

    // R2
    shift_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !$past(rst)) |=> shift_q == $past(shift_q));

    // R3
    transparent_chk: assert property (@(posedge clk) disable iff (rst)
        (!le_n && !clr) |-> sw_en == shift_q);

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (le_n && $past(le_n) && !clr && !$past(clr) && !$past(rst)) |-> $stable(sw_en));

    // R5
    capture_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(le_n) && !clr && !$past(clr) && !$past(rst)) |-> sw_en == shift_q);

    // R6
    clear_off_chk: assert property (@(posedge clk) disable iff (rst)
        clr |-> sw_en == '0);

    // R8
    serial_tap_chk: assert property (@(posedge clk) disable iff (rst)
        (!le_n && !clr) |-> ser_out == sw_en[N_CH-1]);

endmodule

bind swctl_serial_latch swctl_chk #(.N_CH(N_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ser_in   (ser_in),
    .shift_en (shift_en),
    .le_n     (le_n),
    .clr      (clr),
    .sw_en    (sw_en),
    .ser_out  (ser_out),
    .shift_q  (shift_q)
);

// File: tb/swctl_serial_latch_bench.sv
`timescale 1ns/1ps
module swctl_serial_latch_bench;

    localparam int      N       = 8;
    localparam realtime SETUP_NS = 15.0;
    localparam realtime HOLD_NS  = 35.0;
    localparam int      WD_CYC   = 200000;

    logic         clk = 1'b0;
    logic         rst;
    logic         ser_in;
    logic         shift_en;
    logic         le_n;
    logic         clr;
    logic [N-1:0] sw_en;
    logic         ser_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [N-1:0] m_sr;
    logic [N-1:0] m_lat;

    realtime t_sin  = 0.0;
    realtime t_edge = -1.0e6;

    always #4 clk = ~clk;

    swctl_serial_latch #(.N_CH(N)) u_swctl_serial_latch (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .shift_en (shift_en),
        .le_n     (le_n),
        .clr      (clr),
        .sw_en    (sw_en),
        .ser_out  (ser_out)
    );

    // R10 timing monitor on the serial input around qualified edges
    always @(ser_in) begin
        if (!rst && ($realtime - t_edge) < HOLD_NS) begin
            failures++;
            $display("FAIL R10 hold: actual=%0t ns expected>=%0t ns", $realtime - t_edge, HOLD_NS);
        end
        t_sin = $realtime;
    end

    always @(posedge clk) begin
        if (!rst && shift_en) begin
            checks++;
            if (($realtime - t_sin) < SETUP_NS) begin
                failures++;
                $display("FAIL R10 setup: actual=%0t ns expected>=%0t ns", $realtime - t_sin, SETUP_NS);
            end
            t_edge = $realtime;
        end
    end

    task automatic check_val(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_out(input string tag);
        logic [N-1:0] exp_sw;
        exp_sw = clr ? '0 : (le_n ? m_lat : m_sr);
        check_val({tag, " sw_en"}, sw_en, exp_sw);
        check_val({tag, " ser_out (R8)"}, {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, m_sr[N-1]});
    endtask

    task automatic model_edge();
        if (clr)
            m_lat = '0;
        else if (!le_n)
            m_lat = m_sr;
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk) ser_in = b;
        repeat (2) @(negedge clk);
        shift_en = 1'b1;
        @(negedge clk) shift_en = 1'b0;
        m_sr = {m_sr[N-2:0], b};
        model_edge();
        repeat (4) @(negedge clk);
    endtask

    task automatic load_word(input logic [N-1:0] w);
        for (int i = N - 1; i >= 0; i--)
            shift_bit(w[i]);
    endtask

    task automatic set_ctl(input logic le, input logic c);
        @(negedge clk);
        le_n = le;
        clr  = c;
        @(negedge clk);
        model_edge();
    endtask

    initial begin
        #(WD_CYC * 8);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] prev;
        rst = 1'b1; ser_in = 1'b0; shift_en = 1'b0; le_n = 1'b1; clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_sr = '0;
        m_lat = '0;
        @(negedge clk);
        check_out("R1 reset");

        // Full sweep of words with the latch held during shifting
        for (int w = 0; w < (1 << N); w++) begin
            prev = m_lat;
            load_word(w[N-1:0]);
            check_val("R4 hold during shift", sw_en, prev);
            check_val("R8 serial tap", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, w[N-1]});
            set_ctl(1'b0, 1'b0);
            check_out("R3 transparent");
            set_ctl(1'b1, 1'b0);
            check_out("R5 captured");
            check_val("R9 bit order", sw_en, w[N-1:0]);
        end

        // Transparent shifting follows each bit
        set_ctl(1'b0, 1'b0);
        for (int i = N - 1; i >= 0; i--) begin
            shift_bit(i[0] ^ i[1]);
            check_out("R3 follow shift");
        end

        // Unqualified edges leave the register alone
        for (int k = 0; k < 6; k++) begin
            @(negedge clk) ser_in = ~ser_in;
            repeat (6) @(negedge clk);
            check_out("R2 idle edges");
        end

        // Clear while held, shift under clear, then restore
        set_ctl(1'b1, 1'b0);
        load_word(8'h3C);
        set_ctl(1'b0, 1'b0);
        set_ctl(1'b1, 1'b0);
        check_val("R5 latch 3C", sw_en, 8'h3C);
        @(negedge clk) clr = 1'b1;
        #1 check_val("R6 immediate clear", sw_en, '0);
        @(negedge clk);
        model_edge();
        check_out("R6 clear held");
        load_word(8'hC3);
        check_out("R7 shift under clear");
        set_ctl(1'b1, 1'b0);
        check_val("R7 off after release", sw_en, '0);
        check_out("R7 off after release model");
        set_ctl(1'b0, 1'b0);
        set_ctl(1'b1, 1'b0);
        check_val("R7 restore", sw_en, 8'hC3);

        // Clear overrides the transparent mode
        set_ctl(1'b0, 1'b1);
        check_val("R6 clear over transparent", sw_en, '0);
        shift_bit(1'b1);
        check_out("R6 clear while shifting");
        set_ctl(1'b0, 1'b0);
        check_val("R3 after clear", sw_en, 8'h87);
        set_ctl(1'b1, 1'b0);
        check_out("R5 final capture");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule